// File: doc/BRIEF.md
# Tri-State Port Direction Controller

This block owns the direction and drive state of four general-purpose I/O ports: three wide ports of eight pins and one narrow port of two pins. For every pin a direction bit chooses between driving the pin from its output data latch and leaving it floating. Software reaches the latches through a small register bus with a write strobe and a combinational read path. The block presents per-pin output-enable and output-value signals to the pad ring and returns the pin levels through a synchronizer.

The narrow port differs from the wide ones. Its direction register has only two live bits, and the rest read as zero. Its upper pin is restricted to input or open-drain output: it can pull the pad low or release it, but it never drives a high level. Reset leaves every pin floating. A data latch can be loaded before its pin is made an output, so the pin drives a known level from the first cycle it is enabled.

Top module: `pdc_top`

## Requirements
- R1: After reset every direction bit is 1. Every pad_oe_o bit is 0. The wide direction registers read 0xFF and the narrow one reads 0x03.
- R2: A push-pull pin whose direction bit is 0 has pad_oe_o=1 and drives its data latch value on pad_out_o. The push-pull pins are all wide-port pins and narrow pin 0.
- R3: A pin whose direction bit is 1 has pad_oe_o=0.
- R4: The three wide direction registers read back exactly the last byte written to them.
- R5: In the narrow direction register, bits 7..2 always read 0 and writes to them are ignored. Bits 1..0 hold the written value.
- R6: Narrow pin 1 (pad index 25) never drives high. When its direction bit is 0 and its latch is 0, it is enabled and driven low. When its latch is 1 it floats. When its direction bit is 1 it floats.
- R7: Reading a data address returns the pad level passed through a two-flop synchronizer, not the latch. A pad change becomes visible after the second rising edge following it.
- R8: A data write loads the output latch whatever the direction bit holds. The pad stays disabled until its direction bit is cleared, and from then on it drives the stored value.
- R9: Address map: 0,1,2,3 are the data registers of ports A,B,C and the narrow port D. Addresses 4,5,6,7 are their direction registers. Pads are indexed A=[7:0], B=[15:8], C=[23:16], D=[25:24]. Narrow data reads return 0 in bits 7..2.
- R10: Without a register write, pad_oe_o and pad_out_o do not change, even when pad inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| pad_in_i | input | 26 | Pad input levels |
| pad_oe_o | output | 26 | Per-pin output enable |
| pad_out_o | output | 26 | Per-pin output value |

## Verification
The bench loads a data latch while its pin still floats and checks that the pin stays disabled. A design that tied the latch load to direction would drive a stale value once the pin is enabled. The open-drain pin is stepped through every direction and latch combination, so a design that drove it high, or enabled it for a latch value of 1, is caught. The narrow direction register is written with all ones and then with 0xFC, which exposes an implementation that keeps bits 7..2. Pad levels are read one and two edges after they change, with latch values that differ from them. This exposes a design that reads back the latch or uses the wrong number of synchronizer stages.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  localparam int unsigned WIDE_W_DEF   = 8;
  localparam int unsigned WIDE_CNT_DEF = 3;
  localparam int unsigned NARROW_W_DEF = 2;
  localparam int unsigned SYNC_DEF     = 2;

  typedef struct packed {
    logic oe;
    logic val;
  } pad_drv_t;

  // Drive rule for one pin: dir=1 floats; open-drain pins only pull low.
  function automatic pad_drv_t pin_drive(input logic dir, input logic latch,
                                         input logic od);
    pad_drv_t r;
    r.oe  = !dir && (!od || !latch);
    r.val = od ? 1'b0 : latch;
    return r;
  endfunction

endpackage

// File: rtl/pdc_rst_sync.sv
module pdc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic meta_q;
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      out_q  <= meta_q;
    end
  end

  assign rst_no = out_q;

endmodule

// File: rtl/pdc_in_sync.sv
module pdc_in_sync #(
  parameter int unsigned W      = 26,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pdc_port_bank.sv
module pdc_port_bank
  import pdc_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] OD_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dat_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o
);

  logic [W-1:0] dat_d, dat_q;
  logic [W-1:0] dir_d, dir_q;

  // next-state
  always_comb begin
    dat_d = wdata_i;
    dir_d = wdata_i;
  end

  // registers with explicit enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
    end else if (dat_we_i) begin
      dat_q <= dat_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
    end else if (dir_we_i) begin
      dir_q <= dir_d;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    pad_drv_t drv;
    assign drv      = pin_drive(dir_q[i], dat_q[i], OD_MASK[i]);
    assign oe_o[i]  = drv.oe;
    assign out_o[i] = drv.val;
  end

  assign dir_o = dir_q;

endmodule

// File: rtl/pdc_top.sv
module pdc_top
  import pdc_pkg::*;
#(
  parameter int unsigned WIDE_W      = WIDE_W_DEF,
  parameter int unsigned WIDE_CNT    = WIDE_CNT_DEF,
  parameter int unsigned NARROW_W    = NARROW_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  parameter logic [NARROW_W-1:0] NARROW_OD = 2'b10,
  localparam int unsigned PORT_CNT = WIDE_CNT + 1,
  localparam int unsigned PIN_CNT  = WIDE_W * WIDE_CNT + NARROW_W,
  localparam int unsigned ADDR_W   = $clog2(2 * PORT_CNT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [WIDE_W-1:0]   bus_wdata_i,
  output logic [WIDE_W-1:0]   bus_rdata_o,
  input  logic [PIN_CNT-1:0]  pad_in_i,
  output logic [PIN_CNT-1:0]  pad_oe_o,
  output logic [PIN_CNT-1:0]  pad_out_o
);

  localparam int unsigned NARROW_LO = WIDE_W * WIDE_CNT;

  logic                rst_n_q;
  logic [PIN_CNT-1:0]  pin_sync;
  logic [WIDE_W-1:0]   rd_dat [PORT_CNT];
  logic [WIDE_W-1:0]   rd_dir [PORT_CNT];
  logic [PORT_CNT-1:0] dat_we;
  logic [PORT_CNT-1:0] dir_we;

  pdc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  pdc_in_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  // write decode
  for (genvar p = 0; p < PORT_CNT; p++) begin : g_dec
    assign dat_we[p] = bus_we_i && (bus_addr_i == ADDR_W'(p));
    assign dir_we[p] = bus_we_i && (bus_addr_i == ADDR_W'(PORT_CNT + p));
  end

  for (genvar w = 0; w < WIDE_CNT; w++) begin : g_wide
    pdc_port_bank #(.W(WIDE_W), .OD_MASK('0)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_q),
      .dat_we_i (dat_we[w]),
      .dir_we_i (dir_we[w]),
      .wdata_i  (bus_wdata_i),
      .dir_o    (rd_dir[w]),
      .oe_o     (pad_oe_o[w*WIDE_W +: WIDE_W]),
      .out_o    (pad_out_o[w*WIDE_W +: WIDE_W])
    );
    assign rd_dat[w] = pin_sync[w*WIDE_W +: WIDE_W];
  end

  logic [NARROW_W-1:0] narrow_dir;

  pdc_port_bank #(.W(NARROW_W), .OD_MASK(NARROW_OD)) u_narrow (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_q),
    .dat_we_i (dat_we[WIDE_CNT]),
    .dir_we_i (dir_we[WIDE_CNT]),
    .wdata_i  (bus_wdata_i[NARROW_W-1:0]),
    .dir_o    (narrow_dir),
    .oe_o     (pad_oe_o[NARROW_LO +: NARROW_W]),
    .out_o    (pad_out_o[NARROW_LO +: NARROW_W])
  );

  assign rd_dir[WIDE_CNT] = WIDE_W'(narrow_dir);
  assign rd_dat[WIDE_CNT] = WIDE_W'(pin_sync[NARROW_LO +: NARROW_W]);

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    for (int p = 0; p < PORT_CNT; p++) begin
      if (bus_addr_i == ADDR_W'(p))            bus_rdata_o = rd_dat[p];
      if (bus_addr_i == ADDR_W'(PORT_CNT + p)) bus_rdata_o = rd_dir[p];
    end
  end

endmodule

// File: rtl/pdc_sva.sv
module pdc_sva #(
  parameter int unsigned WIDE_W   = 8,
  parameter int unsigned WIDE_CNT = 3,
  parameter int unsigned NARROW_W = 2,
  localparam int unsigned PORT_CNT = WIDE_CNT + 1,
  localparam int unsigned PIN_CNT  = WIDE_W * WIDE_CNT + NARROW_W,
  localparam int unsigned ADDR_W   = $clog2(2 * PORT_CNT),
  localparam int unsigned OD_IDX   = PIN_CNT - 1
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [WIDE_W-1:0]  bus_wdata_i,
  input logic [WIDE_W-1:0]  bus_rdata_o,
  input logic [PIN_CNT-1:0] pad_oe_o,
  input logic [PIN_CNT-1:0] pad_out_o
);

  localparam logic [ADDR_W-1:0] A_DAT_N = ADDR_W'(WIDE_CNT);
  localparam logic [ADDR_W-1:0] A_DIR_0 = ADDR_W'(PORT_CNT);
  localparam logic [ADDR_W-1:0] A_DIR_N = ADDR_W'(PORT_CNT + WIDE_CNT);

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    pad_oe_o[OD_IDX] |-> !pad_out_o[OD_IDX]); // R6

  AST_OD_LATCH_ONE_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == A_DAT_N && bus_wdata_i[1]) |=> !pad_oe_o[OD_IDX]); // R6

  AST_DIR_WRITE_SETS_OE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == A_DIR_0) |=> (pad_oe_o[WIDE_W-1:0] == ~$past(bus_wdata_i))); // R3

  AST_NARROW_DIR_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_addr_i == A_DIR_N) |-> (bus_rdata_o[WIDE_W-1:NARROW_W] == '0)); // R5

  AST_PADS_HOLD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !bus_we_i |=> ($stable(pad_oe_o) && $stable(pad_out_o))); // R10

endmodule

bind pdc_top pdc_sva #(
  .WIDE_W   (WIDE_W),
  .WIDE_CNT (WIDE_CNT),
  .NARROW_W (NARROW_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_n       (rst_n_q),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pad_oe_o    (pad_oe_o),
  .pad_out_o   (pad_out_o)
);

// File: tb/pdc_top_tb_top.sv
`timescale 1ns/1ps
module pdc_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [2:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [25:0] pad_in;
  logic [25:0] pad_oe;
  logic [25:0] pad_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int          kind;   // 0 rdata, 1 pad_oe, 2 pad_out
    logic [25:0] exp;
    logic [25:0] mask;
    string       tag;
  } item_t;

  item_t exp_q [$];

  always #2.5 clk = ~clk;

  pdc_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pad_in_i    (pad_in),
    .pad_oe_o    (pad_oe),
    .pad_out_o   (pad_out)
  );

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [25:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0:       act = {18'd0, rdata};
        1:       act = pad_oe;
        default: act = pad_out;
      endcase
      act = act & it.mask;
      checks++;
      if (act !== (it.exp & it.mask)) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind,
                 act, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    addr = a;
    it.kind = 0; it.exp = {18'd0, e}; it.mask = 26'h00000FF; it.tag = tag;
    exp_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic exp_pad(input int k, input logic [25:0] e, input logic [25:0] m,
                         input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.mask = m; it.tag = tag;
    exp_q.push_back(it);
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pad_in = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    exp_pad(1, 26'h0, 26'h3FFFFFF, "R1");
    exp_rd(3'd4, 8'hFF, "R1");
    exp_rd(3'd5, 8'hFF, "R1");
    exp_rd(3'd6, 8'hFF, "R1");
    exp_rd(3'd7, 8'h03, "R1");

    // R8 latch load while floating, then enable
    wr(3'd0, 8'hC3);
    exp_pad(1, 26'h0, 26'hFF, "R8");
    wr(3'd4, 8'h00);
    exp_pad(1, 26'hFF, 26'hFF, "R2");
    exp_pad(2, 26'hC3, 26'hFF, "R8");

    // R4 / R3 partial direction on port A
    wr(3'd4, 8'h5A);
    exp_rd(3'd4, 8'h5A, "R4");
    exp_pad(1, 26'hA5, 26'hFF, "R3");
    exp_pad(2, 26'h81, 26'hA5, "R2");

    // port B (R9 map)
    wr(3'd1, 8'hAA);
    wr(3'd5, 8'h0F);
    exp_rd(3'd5, 8'h0F, "R4");
    exp_pad(1, 26'hF000, 26'hFF00, "R3");
    exp_pad(2, 26'hA000, 26'hF000, "R9");

    // port C
    wr(3'd6, 8'h00);
    wr(3'd2, 8'h81);
    exp_rd(3'd6, 8'h00, "R9");
    exp_pad(1, 26'hFF0000, 26'hFF0000, "R2");
    exp_pad(2, 26'h810000, 26'hFF0000, "R9");

    // R5 narrow direction upper bits
    wr(3'd7, 8'hFF);
    exp_rd(3'd7, 8'h03, "R5");
    wr(3'd7, 8'hFC);
    exp_rd(3'd7, 8'h00, "R5");

    // R6 open-drain pin
    exp_pad(1, 26'h3000000, 26'h3000000, "R6");
    exp_pad(2, 26'h0, 26'h3000000, "R6");
    wr(3'd3, 8'h03);
    exp_pad(1, 26'h1000000, 26'h3000000, "R6");
    exp_pad(2, 26'h1000000, 26'h1000000, "R2");
    wr(3'd3, 8'h01);
    exp_pad(1, 26'h3000000, 26'h3000000, "R6");
    exp_pad(2, 26'h1000000, 26'h3000000, "R6");
    wr(3'd7, 8'h02);
    exp_pad(1, 26'h1000000, 26'h3000000, "R6");

    // R7 synchronized readback, latch A holds C3
    pad_in[7:0] = 8'h3C;
    exp_rd(3'd0, 8'h00, "R7");
    exp_rd(3'd0, 8'h00, "R7");
    exp_rd(3'd0, 8'h3C, "R7");
    pad_in[25:24] = 2'b10;
    pad_in[15:8]  = 8'h55;
    repeat (3) @(posedge clk);
    #1;
    exp_rd(3'd3, 8'h02, "R7");
    exp_rd(3'd1, 8'h55, "R7");

    // R10 no writes: pad inputs toggle, drive unchanged
    pad_in = '1;
    repeat (3) @(posedge clk);
    #1;
    exp_pad(1, 26'h1FFF0A5, 26'h3FFFFFF, "R10");
    exp_pad(2, 26'h181A081, 26'h1FFF0A5, "R10");

    @(posedge clk); #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule